// File: doc/BRIEF.md
# Speculative L1 Line State Controller

This block holds the per-line state of a small private L1 cache that runs speculative threads. The cache is direct-mapped, write-through and does not allocate on stores. Each line keeps a tag and four flags: valid, speculatively-loaded (SL), speculatively-modified (SM) and stale. The block decides hit or miss for each processor request with these flags taken into account. It allocates lines on load misses. When the thread commits or is rolled back, it flash-updates every line in one cycle.

The first speculative load of a line in an epoch places the line address into a small notify queue. A downstream shared cache drains that queue, so it can track which lines the epoch has read. Escape and resume pulses move the cache into and out of a mode where the thread runs non-speculatively. In that mode, lines holding speculative changes are hidden, and lines brought in are marked stale. Data arrays and replacement are outside this block.

Top module: `spec_l1_state`

## Requirements
- R1: Line index is `req_addr[IDX_W-1:0]` and tag is the remaining upper bits. A request hits only if the indexed line is valid with an equal tag and is not hidden by R6 or R7. A load miss allocates the indexed line unless that line is valid with SM set. After reset every line is invalid.
- R2: Every store is written through (`rsp_write`=1) and a store miss never allocates. A speculative store that hits sets SM on the line.
- R3: A speculative load that hits sets SL. A speculative load that allocates sets SL. Any speculative load where the line did not already hit with SL set pushes its line address into the notify queue. A speculative load hit on a line with SL set pushes nothing.
- R4: The notify queue holds `NTF_DEPTH` entries. It presents them in push order on `ntf_valid`/`ntf_addr`, and each entry is removed on a cycle with `ntf_ready`=1.
- R5: When the queue is full, `req_ready` is low for a request that would push a notify. It stays low until an entry leaves. Requests that need no notify remain ready.
- R6: While escaped (after an `escape` pulse, until a `resume` pulse), a line with SM set is a miss and is not replaced. `req_spec` is ignored, so every request is non-speculative.
- R7: A line allocated while escaped is stale. A speculative request to a stale line misses. A speculative load then refetches the line, clearing stale and setting SL.
- R8: `commit` clears SL, SM and stale on every line and leaves valid unchanged.
- R9: `violate` invalidates every line with SM set and clears SL, SM and stale everywhere. If `commit` and `violate` are asserted together, the violate behaviour applies.
- R10: A non-speculative request never sets SL or SM and never pushes a notify.
- R11: A request accepted on a clock edge returns `rsp_valid`, `rsp_hit` and `rsp_write` right after that edge. `req_ready` is low in any cycle where `commit` or `violate` is high.
- R12: After reset, `rsp_valid` and `ntf_valid` are low and an idle request port is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_spec | input | 1 | Request issued by speculative work |
| req_addr | input | ADDR_W | Line address |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Response for the request accepted on the previous edge |
| rsp_hit | output | 1 | Response was a hit |
| rsp_write | output | 1 | Response was a store, written through |
| commit | input | 1 | Epoch commit pulse |
| violate | input | 1 | Epoch rollback pulse |
| escape | input | 1 | Leave speculation |
| resume | input | 1 | Re-enter speculation |
| ntf_valid | output | 1 | Notify queue not empty |
| ntf_addr | output | ADDR_W | Oldest queued line address |
| ntf_ready | input | 1 | Downstream takes the oldest notify |

## Verification
A wrong flag bit in a line shows up at the ports on the next request to that line. A lost SM or stale bit turns an expected miss into a hit on the very next response. A stuck SL bit either suppresses or duplicates a notify entry, which is visible one edge later on `ntf_valid`. Missed flash updates show up on the first access after a commit or violate. A miscounted queue appears as a wrong `req_ready` in the cycle a notify is needed while four are pending.

// File: rtl/spec_l1_pkg.sv
package spec_l1_pkg;
  typedef struct packed {
    logic valid;
    logic sl;
    logic sm;
    logic stale;
  } line_flags_t;
endpackage

// File: rtl/spec_l1_notify_fifo.sv
module spec_l1_notify_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign head    = store_q[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_q] <= push_data;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/spec_l1_line.sv
module spec_l1_line
  import spec_l1_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             violate,
  input  logic             upd,
  input  line_flags_t      upd_flags,
  input  logic [TAG_W-1:0] upd_tag,
  output line_flags_t      flags_q,
  output logic [TAG_W-1:0] tag_q
);
  line_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (violate) begin
      flags_d.valid = flags_q.valid && !flags_q.sm;
      flags_d.sl    = 1'b0;
      flags_d.sm    = 1'b0;
      flags_d.stale = 1'b0;
    end else if (commit) begin
      flags_d.sl    = 1'b0;
      flags_d.sm    = 1'b0;
      flags_d.stale = 1'b0;
    end else if (upd) begin
      flags_d = upd_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_ff @(posedge clk) begin
    if (upd && !commit && !violate) tag_q <= upd_tag;
  end

  assert_violate_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    violate |=> (!flags_q.sm && !flags_q.sl && !flags_q.stale));
  assert_violate_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (violate && flags_q.sm) |=> !flags_q.valid);
  assert_commit_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !violate && flags_q.valid) |=> (flags_q.valid && !flags_q.sm && !flags_q.sl));
endmodule

// File: rtl/spec_l1_state.sv
module spec_l1_state
  import spec_l1_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LINES     = 8,
  parameter int NTF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_spec,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_write,
  input  logic              commit,
  input  logic              violate,
  input  logic              escape,
  input  logic              resume,
  output logic              ntf_valid,
  output logic [ADDR_W-1:0] ntf_addr,
  input  logic              ntf_ready
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_flags_t      flags_q [LINES];
  logic [TAG_W-1:0] tags_q  [LINES];

  logic             escaped_q, escaped_d;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] req_tag;
  line_flags_t      cur_f, new_f;
  logic             eff_spec, hit, need_ntf, alloc, accept, upd_any;
  logic             fifo_full, fifo_empty;
  logic             rsp_valid_q, rsp_hit_q, rsp_write_q;

  assign idx     = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];

  always_comb begin
    cur_f    = flags_q[idx];
    eff_spec = req_spec && !escaped_q;
    hit      = cur_f.valid && (tags_q[idx] == req_tag)
               && !(escaped_q && cur_f.sm)
               && !(eff_spec && cur_f.stale);
    need_ntf = !req_write && eff_spec && !(hit && cur_f.sl);
    alloc    = !req_write && !hit && !(cur_f.valid && cur_f.sm);
    req_ready = !(commit || violate) && !(need_ntf && fifo_full);
    accept   = req_valid && req_ready;
    new_f    = cur_f;
    if (alloc) begin
      new_f.valid = 1'b1;
      new_f.sl    = eff_spec;
      new_f.sm    = 1'b0;
      new_f.stale = escaped_q;
    end else if (hit && eff_spec) begin
      if (req_write) new_f.sm = 1'b1;
      else           new_f.sl = 1'b1;
    end
    upd_any  = accept && (alloc || (hit && eff_spec));
  end

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    spec_l1_line #(.TAG_W(TAG_W)) line_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .violate  (violate),
      .upd      (upd_any && (idx == IDX_W'(gi))),
      .upd_flags(new_f),
      .upd_tag  (req_tag),
      .flags_q  (flags_q[gi]),
      .tag_q    (tags_q[gi])
    );
  end

  spec_l1_notify_fifo #(.DEPTH(NTF_DEPTH), .W(ADDR_W)) ntf_fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept && need_ntf),
    .push_data(req_addr),
    .pop      (ntf_ready),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .head     (ntf_addr)
  );
  assign ntf_valid = !fifo_empty;

  always_comb begin
    escaped_d = escaped_q;
    if (escape)      escaped_d = 1'b1;
    else if (resume) escaped_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      escaped_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_write_q <= 1'b0;
    end else begin
      escaped_q   <= escaped_d;
      rsp_valid_q <= accept;
      if (accept) begin
        rsp_hit_q   <= hit;
        rsp_write_q <= req_write;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_write = rsp_write_q;

  assert_ctl_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || violate) |-> !req_ready);
  assert_rsp_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  assert_nonspec_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_spec && !escaped_q) && !ntf_ready && !ntf_valid) |=> !ntf_valid);
  assert_store_nofill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !flags_q[idx].valid && !commit && !violate)
      |=> !flags_q[$past(idx)].valid);
endmodule

// File: tb/spec_l1_state_tb_top.sv
module spec_l1_state_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, req_spec;
  logic [7:0] req_addr;
  logic       req_ready, rsp_valid, rsp_hit, rsp_write;
  logic       commit, violate, escape, resume;
  logic       ntf_valid, ntf_ready;
  logic [7:0] ntf_addr;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  spec_l1_state dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_spec(req_spec), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_write(rsp_write),
    .commit(commit), .violate(violate), .escape(escape), .resume(resume),
    .ntf_valid(ntf_valid), .ntf_addr(ntf_addr), .ntf_ready(ntf_ready)
  );

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a response appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected response", 8'd1, 8'd0);
      end else begin
        logic [1:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {6'd0, rsp_hit, rsp_write}, {6'd0, e});
      end
    end
  end

  task automatic acc(input logic w, input logic s, input logic [7:0] a,
                     input logic exp_hit, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_spec = s; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_q.push_back({exp_hit, w});
    tag_q.push_back(t);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(input logic w, input logic s, input logic [7:0] a,
                       input logic exp_rdy, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_spec = s; req_addr = a;
    #1;
    chk(t, {7'd0, req_ready}, {7'd0, exp_rdy});
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic c, input logic v, input logic e, input logic r);
    @(negedge clk);
    commit = c; violate = v; escape = e; resume = r;
    @(posedge clk); #1;
    commit = 0; violate = 0; escape = 0; resume = 0;
  endtask

  task automatic take_ntf(input logic [7:0] a, input string t);
    @(negedge clk);
    chk({t, " valid"}, {7'd0, ntf_valid}, 8'd1);
    chk({t, " addr"}, ntf_addr, a);
    ntf_ready = 1'b1;
    @(posedge clk); #1;
    ntf_ready = 1'b0;
  endtask

  task automatic no_ntf(input string t);
    @(negedge clk);
    chk(t, {7'd0, ntf_valid}, 8'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_spec = 0; req_addr = 0;
    commit = 0; violate = 0; escape = 0; resume = 0; ntf_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    chk("R12 ntf_valid", {7'd0, ntf_valid}, 8'd0);
    chk("R12 ready", {7'd0, req_ready}, 8'd1);

    // R1 allocation and tag compare; R10 non-spec quiet
    acc(0, 0, 8'h10, 0, "R1 cold load miss");
    acc(0, 0, 8'h10, 1, "R1 reload hit");
    acc(0, 0, 8'h18, 0, "R1 tag mismatch miss");
    acc(0, 0, 8'h10, 0, "R1 replaced line miss");
    acc(0, 0, 8'h10, 1, "R1 refilled hit");
    no_ntf("R10 no notify from non-spec");

    // R3 first speculative load notifies once
    acc(0, 1, 8'h10, 1, "R3 spec load hit");
    take_ntf(8'h10, "R3 first notify");
    acc(0, 1, 8'h10, 1, "R3 repeat spec load hit");
    no_ntf("R3 no second notify");

    // R2 store write-through, no allocate, SM on spec hit
    acc(1, 0, 8'h21, 0, "R2 store miss");
    acc(0, 0, 8'h21, 0, "R2 no allocate on store");
    acc(1, 1, 8'h21, 1, "R2 spec store hit");
    acc(0, 0, 8'h29, 0, "R1 SM line not replaced miss");
    acc(0, 0, 8'h21, 1, "R1 SM line kept");

    // R6 escape hides SM lines and ignores req_spec
    pulse(0, 0, 1, 0);
    acc(0, 0, 8'h21, 0, "R6 SM line misses while escaped");
    acc(0, 0, 8'h10, 1, "R6 clean line hits while escaped");
    acc(0, 1, 8'h10, 1, "R6 spec flag ignored");
    no_ntf("R6 no notify while escaped");
    pulse(0, 0, 0, 1);
    acc(0, 1, 8'h21, 1, "R6 SM line visible after resume");
    take_ntf(8'h21, "R3 notify on SM line");

    // R9 violate drops SM lines, clears SL
    pulse(0, 1, 0, 0);
    acc(0, 0, 8'h21, 0, "R9 SM line invalid after violate");
    acc(0, 0, 8'h10, 1, "R9 clean line survives");
    acc(0, 1, 8'h10, 1, "R9 SL cleared spec hit");
    take_ntf(8'h10, "R9 notify again after violate");

    // R8 commit keeps line, clears SM
    acc(1, 1, 8'h10, 1, "R8 spec store sets SM");
    pulse(1, 0, 0, 0);
    pulse(0, 0, 1, 0);
    acc(0, 0, 8'h10, 1, "R8 line valid and clean after commit");
    // R7 stale allocation
    acc(0, 0, 8'h32, 0, "R7 escaped fill miss");
    pulse(0, 0, 0, 1);
    acc(0, 0, 8'h32, 1, "R7 stale line hits non-spec");
    acc(0, 1, 8'h32, 0, "R7 stale line misses spec");
    take_ntf(8'h32, "R7 refetch notify");
    acc(0, 1, 8'h32, 1, "R7 refetch clears stale");
    no_ntf("R3 no notify after refetch");
    pulse(0, 0, 1, 0);
    acc(0, 0, 8'h43, 0, "R7 escaped fill");
    pulse(0, 0, 0, 1);
    pulse(1, 0, 0, 0);
    acc(0, 1, 8'h43, 1, "R8 commit clears stale");
    take_ntf(8'h43, "R8 notify after commit");

    // R9 violate wins over commit
    acc(1, 1, 8'h10, 1, "R9 spec store before dual pulse");
    pulse(1, 1, 0, 0);
    acc(0, 0, 8'h10, 0, "R9 violate wins");

    // R4 / R5 queue order and full stall
    acc(0, 1, 8'h14, 0, "R4 spec miss a");
    acc(0, 1, 8'h15, 0, "R4 spec miss b");
    acc(0, 1, 8'h16, 0, "R4 spec miss c");
    acc(0, 1, 8'h17, 0, "R4 spec miss d");
    probe(0, 1, 8'h10, 0, "R5 stall when full");
    probe(0, 0, 8'h14, 1, "R5 non-notify request ready");
    probe(0, 1, 8'h14, 1, "R5 spec hit with SL ready");
    take_ntf(8'h14, "R4 order 0");
    acc(0, 1, 8'h10, 1, "R5 accepted after space");
    take_ntf(8'h15, "R4 order 1");
    take_ntf(8'h16, "R4 order 2");
    take_ntf(8'h17, "R4 order 3");
    take_ntf(8'h10, "R4 order 4");
    no_ntf("R4 drained");

    repeat (2) @(negedge clk);
    chk("R11 scoreboard empty", 8'(exp_q.size()), 8'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule